// File: doc/BRIEF.md
# Region Write-Lock Command Recognizer

This block sits in front of a byte-wide nonvolatile array and decides, for each qualified write, whether that write may reach the array. The array is split into equal regions. Each region has its own lock flag. A lock flag is set or cleared only by writing fixed address/data command patterns into that region. The flags are held in registers that only an explicit test reset clears. The ordinary reset, which stands for a power transition, leaves them untouched.

A write burst ends when the page engine's byte-load timer expires. That engine is outside this block and signals the expiry with a one-cycle `burst_end_i` pulse. A lock or unlock command takes effect only at that pulse. While a region is locked, a burst is accepted only when it starts with the three-write unlock pattern. The number of data bytes that may follow the pattern is limited to one page. Accepted writes come out one cycle later on a registered pass port, with their address and data.

Top module: `wp_seq_guard`

## Requirements
- R1: `test_rst` clears every lock flag to 0 (all regions unlocked). `rst` clears the command state and drives `pass_o` low. After both resets `prot_o` is 0.
- R2: `rst` alone does not change any lock flag.
- R3: A write to an unlocked region always passes. This includes writes that are command steps.
- R4: The lock pattern sets the region's flag at the next `burst_end_i` pulse, even if no data byte follows it. The pattern is three writes into the region, compared on address bits 14..0 and all 8 data bits: 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555.
- R5: In a locked region, a write that is not preceded in the same burst by the complete three-write pattern is dropped. The command writes themselves are dropped as well.
- R6: In a locked region, after the three-write pattern, up to PAGE_BYTES (128) data writes pass until `burst_end_i`. Further writes in that burst are dropped.
- R7: The unlock-forever pattern clears the region's flag at the next `burst_end_i` pulse. It is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Data writes that follow it in the same burst pass.
- R8: A write that does not match the next expected step returns that region's recognizer to idle. A later 0xA0@0x5555 then does not open the region.
- R9: A `burst_end_i` pulse abandons any partial pattern.
- R10: The region index is address bits 18..17. Commands in one region affect only that region's flag, and any combination of flags may be set.
- R11: Lock flags change only in the cycle after `burst_end_i` or `test_rst`.
- R12: `pass_o` rises in the cycle after an accepted write and carries that write's address and data. It is low in any cycle after one with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of command state and pass port (power transition) |
| test_rst | input | 1 | Synchronous reset of the lock flags |
| wr_valid_i | input | 1 | Qualified write strobe |
| wr_addr_i | input | 19 | Write byte address; bits 18..17 select the region |
| wr_data_i | input | 8 | Write data byte |
| burst_end_i | input | 1 | One-cycle pulse at expiry of the byte-load window |
| pass_o | output | 1 | Registered: previous write may reach the array |
| pass_addr_o | output | 19 | Address of the passed write |
| pass_data_o | output | 8 | Data of the passed write |
| prot_o | output | 4 | Lock flag per region |

## Verification
The hardest situation to reach is a locked region receiving a burst that is opened and then runs past the page limit. The bench first locks a region with the lock pattern and a burst end. It then sends the unlock pattern followed by 130 data writes, which shows both the 128-byte cap and that the three command writes are dropped. Broken and timer-aborted partial patterns are driven on purpose before a lone 0xA0 step. A random phase mixes full lock/unlock patterns, command-like bytes and burst ends across regions, and a behavioural model is compared with the outputs on every clock.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CMD_AW = 15;

  localparam logic [CMD_AW-1:0] CMD_ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] CMD_ADDR_LO = 15'h2AAA;

  localparam logic [BYTE_W-1:0] CMD_KEY1   = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_KEY2   = 8'h55;
  localparam logic [BYTE_W-1:0] CMD_LOCK   = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_ERASEP = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_FREE   = 8'h20;

  typedef enum logic [2:0] {
    TOK_NONE,
    TOK_KEY1,
    TOK_KEY2,
    TOK_LOCK,
    TOK_ERASEP,
    TOK_FREE
  } wp_tok_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_X3,
    ST_X4,
    ST_X5,
    ST_OPEN
  } wp_state_e;

endpackage

// File: rtl/wp_tok_decode.sv
module wp_tok_decode
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output wp_tok_e           tok_o
);

  logic [CMD_AW-1:0] low_addr;
  logic              at_hi;
  logic              at_lo;

  assign low_addr = addr_i[CMD_AW-1:0];
  assign at_hi    = (low_addr == CMD_ADDR_HI);
  assign at_lo    = (low_addr == CMD_ADDR_LO);

  always_comb begin
    tok_o = TOK_NONE;
    if (at_hi && data_i == CMD_KEY1)        tok_o = TOK_KEY1;
    else if (at_lo && data_i == CMD_KEY2)   tok_o = TOK_KEY2;
    else if (at_hi && data_i == CMD_LOCK)   tok_o = TOK_LOCK;
    else if (at_hi && data_i == CMD_ERASEP) tok_o = TOK_ERASEP;
    else if (at_hi && data_i == CMD_FREE)   tok_o = TOK_FREE;
  end

endmodule

// File: rtl/wp_region_ctl.sv
module wp_region_ctl
  import wp_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 128,
  localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    test_rst,
  input  logic    hit_i,
  input  wp_tok_e tok_i,
  input  logic    burst_end_i,
  output logic    allow_o,
  output logic    lock_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_BYTES);

  wp_state_e        state_q, state_d;
  logic             set_pend_q, set_pend_d;
  logic             clr_pend_q, clr_pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q;
  logic             room;

  assign room    = (cnt_q < CNT_MAX);
  assign allow_o = hit_i && (!lock_q || (state_q == ST_OPEN && room));
  assign lock_o  = lock_q;

  always_comb begin
    state_d    = state_q;
    set_pend_d = set_pend_q;
    clr_pend_d = clr_pend_q;
    cnt_d      = cnt_q;
    if (burst_end_i) begin
      state_d    = ST_IDLE;
      set_pend_d = 1'b0;
      clr_pend_d = 1'b0;
      cnt_d      = '0;
    end else if (hit_i) begin
      unique case (state_q)
        ST_IDLE: state_d = (tok_i == TOK_KEY1) ? ST_K1 : ST_IDLE;
        ST_K1:   state_d = (tok_i == TOK_KEY2) ? ST_K2 : ST_IDLE;
        ST_K2: begin
          if (tok_i == TOK_LOCK) begin
            state_d    = ST_OPEN;
            set_pend_d = 1'b1;
          end else if (tok_i == TOK_ERASEP) begin
            state_d = ST_X3;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_X3:   state_d = (tok_i == TOK_KEY1) ? ST_X4 : ST_IDLE;
        ST_X4:   state_d = (tok_i == TOK_KEY2) ? ST_X5 : ST_IDLE;
        ST_X5: begin
          if (tok_i == TOK_FREE) begin
            state_d    = ST_OPEN;
            clr_pend_d = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_OPEN: begin
          if (room) cnt_d = cnt_q + 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      set_pend_q <= 1'b0;
      clr_pend_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q    <= state_d;
      set_pend_q <= set_pend_d;
      clr_pend_q <= clr_pend_d;
      cnt_q      <= cnt_d;
    end
  end

  // Persistent flag: only the test reset clears it.
  always_ff @(posedge clk) begin
    if (test_rst) begin
      lock_q <= 1'b0;
    end else if (burst_end_i && !rst) begin
      if (set_pend_q)      lock_q <= 1'b1;
      else if (clr_pend_q) lock_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wp_pass_reg.sv
module wp_pass_reg
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [BYTE_W-1:0] data_d,
  output logic              pass_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTE_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pass_d) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned REGION_AW   = 17,
  parameter int unsigned PAGE_BYTES  = 128,
  localparam int unsigned RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned ADDR_W = REGION_AW + RIDX_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   test_rst,
  input  logic                   wr_valid_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  input  logic                   burst_end_i,
  output logic                   pass_o,
  output logic [ADDR_W-1:0]      pass_addr_o,
  output logic [BYTE_W-1:0]      pass_data_o,
  output logic [NUM_REGIONS-1:0] prot_o
);

  wp_tok_e                tok;
  logic [RIDX_W-1:0]      ridx;
  logic [NUM_REGIONS-1:0] allow_vec;
  logic [NUM_REGIONS-1:0] lock_vec;

  assign ridx = wr_addr_i[ADDR_W-1 -: RIDX_W];

  wp_tok_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr_i (wr_addr_i),
    .data_i (wr_data_i),
    .tok_o  (tok)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic hit;
    assign hit = wr_valid_i && (ridx == RIDX_W'(g));

    wp_region_ctl #(.PAGE_BYTES(PAGE_BYTES)) ctl_i (
      .clk         (clk),
      .rst         (rst),
      .test_rst    (test_rst),
      .hit_i       (hit),
      .tok_i       (tok),
      .burst_end_i (burst_end_i),
      .allow_o     (allow_vec[g]),
      .lock_o      (lock_vec[g])
    );
  end

  assign prot_o = lock_vec;

  wp_pass_reg #(.ADDR_W(ADDR_W)) out_i (
    .clk    (clk),
    .rst    (rst),
    .pass_d (|allow_vec),
    .addr_d (wr_addr_i),
    .data_d (wr_data_i),
    .pass_q (pass_o),
    .addr_q (pass_addr_o),
    .data_q (pass_data_o)
  );

endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk
  import wp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 4,
  parameter int unsigned REGION_AW   = 17,
  localparam int unsigned RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned ADDR_W = REGION_AW + RIDX_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   test_rst,
  input logic                   wr_valid_i,
  input logic [ADDR_W-1:0]      wr_addr_i,
  input logic [BYTE_W-1:0]      wr_data_i,
  input logic                   burst_end_i,
  input logic                   pass_o,
  input logic [ADDR_W-1:0]      pass_addr_o,
  input logic [BYTE_W-1:0]      pass_data_o,
  input logic [NUM_REGIONS-1:0] prot_o
);

  logic [RIDX_W-1:0] cidx;
  logic              open_hit;

  assign cidx     = wr_addr_i[ADDR_W-1 -: RIDX_W];
  assign open_hit = wr_valid_i && !prot_o[cidx];

  a_r12_no_spurious_pass: assert property (@(posedge clk) disable iff (rst)
    !wr_valid_i |=> !pass_o);

  a_r12_data_follows: assert property (@(posedge clk) disable iff (rst)
    wr_valid_i |=> (!pass_o || (pass_data_o == $past(wr_data_i) &&
                                pass_addr_o == $past(wr_addr_i))));

  a_r3_unlocked_passes: assert property (@(posedge clk) disable iff (rst)
    open_hit |=> pass_o);

  a_r11_flags_hold: assert property (@(posedge clk) disable iff (test_rst)
    !burst_end_i |=> $stable(prot_o));

  a_r1_test_reset_clears: assert property (@(posedge clk) disable iff (rst)
    test_rst |=> (prot_o == '0));

endmodule

bind wp_seq_guard wp_seq_guard_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .REGION_AW   (REGION_AW)
) chk_i (.*);

// File: tb/wp_seq_guard_tb_top.sv
module wp_seq_guard_tb_top;

  localparam int NR = 4;
  localparam int AW = 19;
  localparam int PAGE = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          test_rst = 1'b1;
  logic          wr_valid_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic          burst_end_i = 1'b0;
  logic          pass_o;
  logic [AW-1:0] pass_addr_o;
  logic [7:0]    pass_data_o;
  logic [NR-1:0] prot_o;

  int tests = 0;
  int fails = 0;
  int pass_cnt = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  wp_seq_guard dut_i (
    .clk(clk), .rst(rst), .test_rst(test_rst),
    .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .burst_end_i(burst_end_i), .pass_o(pass_o), .pass_addr_o(pass_addr_o),
    .pass_data_o(pass_data_o), .prot_o(prot_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_state[NR];  // 0 idle, 1..5 steps seen, 6 open
  int m_flag[NR];
  int m_pend[NR];   // 0 none, 1 lock, 2 free
  int m_cnt[NR];
  bit exp_pass = 1'b0;
  logic [AW-1:0] exp_addr;
  logic [7:0]    exp_data;

  function automatic int tok_of(logic [AW-1:0] a, logic [7:0] d);
    int lo;
    lo = int'(a[14:0]);
    if (lo == 'h5555 && d == 8'hAA) return 1;
    if (lo == 'h2AAA && d == 8'h55) return 2;
    if (lo == 'h5555 && d == 8'hA0) return 3;
    if (lo == 'h5555 && d == 8'h80) return 4;
    if (lo == 'h5555 && d == 8'h20) return 5;
    return 0;
  endfunction

  always @(posedge clk) begin
    int r;
    int k;
    if (rst) begin
      exp_pass = 1'b0;
      for (int i = 0; i < NR; i++) begin
        m_state[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      exp_pass = 1'b0;
      if (wr_valid_i) begin
        r = int'(wr_addr_i[18:17]);
        k = tok_of(wr_addr_i, wr_data_i);
        if (m_flag[r] == 0) exp_pass = 1'b1;
        else if (m_state[r] == 6 && m_cnt[r] < PAGE) exp_pass = 1'b1;
        exp_addr = wr_addr_i;
        exp_data = wr_data_i;
        if (!burst_end_i) begin
          case (m_state[r])
            0: m_state[r] = (k == 1) ? 1 : 0;
            1: m_state[r] = (k == 2) ? 2 : 0;
            2: if (k == 3) begin m_state[r] = 6; m_pend[r] = 1; end
               else m_state[r] = (k == 4) ? 3 : 0;
            3: m_state[r] = (k == 1) ? 4 : 0;
            4: m_state[r] = (k == 2) ? 5 : 0;
            5: if (k == 5) begin m_state[r] = 6; m_pend[r] = 2; end
               else m_state[r] = 0;
            default: if (m_cnt[r] < PAGE) m_cnt[r] = m_cnt[r] + 1;
          endcase
        end
      end
      if (burst_end_i) begin
        for (int i = 0; i < NR; i++) begin
          if (m_pend[i] == 1) m_flag[i] = 1;
          else if (m_pend[i] == 2) m_flag[i] = 0;
          m_state[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
        end
      end
    end
    if (test_rst) for (int i = 0; i < NR; i++) m_flag[i] = 0;
  end

  function automatic logic [NR-1:0] model_flags();
    logic [NR-1:0] v;
    for (int i = 0; i < NR; i++) v[i] = (m_flag[i] != 0);
    return v;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (pass_o) pass_cnt++;
    if (cmp_en) begin
      tests++;
      if (pass_o !== exp_pass ||
          (exp_pass && (pass_addr_o !== exp_addr || pass_data_o !== exp_data)) ||
          prot_o !== model_flags()) begin
        fails++;
        $display("FAIL R12 per-cycle: pass=%0b addr=%h data=%h prot=%b expected pass=%0b addr=%h data=%h prot=%b",
                 pass_o, pass_addr_o, pass_data_o, prot_o,
                 exp_pass, exp_addr, exp_data, model_flags());
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int r, input logic [14:0] lo);
    logic [1:0] rr;
    rr = r[1:0];
    return {rr, 2'b00, lo};
  endfunction

  task automatic wr(input int r, input logic [14:0] lo, input logic [7:0] d);
    wr_valid_i = 1'b1;
    wr_addr_i  = mk(r, lo);
    wr_data_i  = d;
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bend();
    burst_end_i = 1'b1;
    @(negedge clk);
    burst_end_i = 1'b0;
  endtask

  task automatic lock_seq(input int r);
    wr(r, 15'h5555, 8'hAA);
    wr(r, 15'h2AAA, 8'h55);
    wr(r, 15'h5555, 8'hA0);
  endtask

  task automatic free_seq(input int r);
    wr(r, 15'h5555, 8'hAA);
    wr(r, 15'h2AAA, 8'h55);
    wr(r, 15'h5555, 8'h80);
    wr(r, 15'h5555, 8'hAA);
    wr(r, 15'h2AAA, 8'h55);
    wr(r, 15'h5555, 8'h20);
  endtask

  int base;

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_state[i] = 0; m_flag[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
    end
    idle(3);
    rst = 1'b0;
    test_rst = 1'b0;
    idle(1);
    cmp_en = 1'b1;

    // R1: reset state
    check(prot_o == 4'b0000, "R1 flags after reset", int'(prot_o), 0);
    check(pass_o == 1'b0, "R1 pass low after reset", int'(pass_o), 0);

    // R3: unlocked region passes, including a command-like byte
    base = pass_cnt;
    wr(0, 15'h0123, 8'h3C);
    check(pass_o == 1'b1 && pass_data_o == 8'h3C, "R3 plain write passes", int'(pass_data_o), 'h3C);
    wr(0, 15'h5555, 8'hAA);
    idle(1);
    check(pass_cnt - base == 2, "R3 command byte passes while unlocked", pass_cnt - base, 2);

    // R4 / R10 / R11: lock region 1 with no data, take effect at burst end
    lock_seq(1);
    idle(2);
    check(prot_o == 4'b0000, "R11 flag waits for burst end", int'(prot_o), 0);
    bend();
    check(prot_o == 4'b0010, "R4 lock region 1 at burst end", int'(prot_o), 2);

    // R5: plain write to locked region dropped
    base = pass_cnt;
    wr(1, 15'h0040, 8'h11);
    idle(1);
    check(pass_cnt == base, "R5 write to locked region dropped", pass_cnt - base, 0);
    wr(2, 15'h0040, 8'h22);
    idle(1);
    check(pass_cnt - base == 1, "R10 other region still open", pass_cnt - base, 1);

    // R2: power reset keeps flags
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    check(prot_o == 4'b0010, "R2 flag survives rst", int'(prot_o), 2);

    // R5 / R6: unlock burst with 130 data bytes
    base = pass_cnt;
    lock_seq(1);
    idle(1);
    check(pass_cnt == base, "R5 command writes dropped while locked", pass_cnt - base, 0);
    for (int i = 0; i < PAGE + 2; i++) wr(1, 15'(i), 8'(i));
    idle(1);
    check(pass_cnt - base == PAGE, "R6 page cap", pass_cnt - base, PAGE);
    bend();
    check(prot_o == 4'b0010, "R4 still locked after burst", int'(prot_o), 2);

    // R8: broken pattern returns to idle
    base = pass_cnt;
    wr(1, 15'h5555, 8'hAA);
    wr(1, 15'h2AAA, 8'h55);
    wr(1, 15'h5555, 8'h12);
    wr(1, 15'h5555, 8'hA0);
    wr(1, 15'h0001, 8'h77);
    idle(1);
    check(pass_cnt == base, "R8 broken pattern does not open", pass_cnt - base, 0);
    bend();

    // R9: burst end abandons a partial pattern
    base = pass_cnt;
    wr(1, 15'h5555, 8'hAA);
    wr(1, 15'h2AAA, 8'h55);
    bend();
    wr(1, 15'h5555, 8'hA0);
    wr(1, 15'h0002, 8'h78);
    idle(1);
    check(pass_cnt == base, "R9 partial pattern abandoned", pass_cnt - base, 0);
    bend();

    // R10: lock region 3 too, combination of flags
    lock_seq(3);
    bend();
    check(prot_o == 4'b1010, "R10 independent flags", int'(prot_o), 'hA);

    // R7: free region 1, data passes in same burst
    base = pass_cnt;
    free_seq(1);
    wr(1, 15'h0100, 8'h5A);
    wr(1, 15'h0101, 8'hA5);
    idle(1);
    check(pass_cnt - base == 2, "R7 data after free pattern passes", pass_cnt - base, 2);
    check(prot_o == 4'b1010, "R11 flag holds until burst end", int'(prot_o), 'hA);
    bend();
    check(prot_o == 4'b1000, "R7 region 1 freed", int'(prot_o), 8);

    // R12: no write gives no pass
    idle(1);
    check(pass_o == 1'b0, "R12 idle cycle no pass", int'(pass_o), 0);

    // random phase, compared every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      int r;
      op = int'($urandom % 100);
      r  = int'($urandom % NR);
      if (op < 4) lock_seq(r);
      else if (op < 7) free_seq(r);
      else if (op < 12) bend();
      else if (op < 70) begin
        logic [14:0] lo;
        logic [7:0]  d;
        case ($urandom % 3)
          0: lo = 15'h5555;
          1: lo = 15'h2AAA;
          default: lo = 15'($urandom);
        endcase
        case ($urandom % 6)
          0: d = 8'hAA;
          1: d = 8'h55;
          2: d = 8'hA0;
          3: d = 8'h80;
          4: d = 8'h20;
          default: d = 8'($urandom);
        endcase
        wr(r, lo, d);
      end else idle(1);
    end

    // R1: test reset clears all flags
    lock_seq(0);
    bend();
    test_rst = 1'b1;
    idle(1);
    test_rst = 1'b0;
    check(prot_o == 4'b0000, "R1 test reset clears flags", int'(prot_o), 0);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule